// File: doc/BRIEF.md
# Multichannel Synchronized Pulse Generator

This block drives a bank of power output channels with repetitive gate-drive pulses. One shared tick counter sets the timing for every channel, so all channels rise and fall on the same clock edge. The counter runs from zero to the active period count minus one and then wraps.

Two digitized setpoints set the pulse shape. A period code maps linearly onto the period count, and the result is clamped between the fastest and the slowest allowed repetition rate. A width code multiplied by a fixed factor gives the on-time, which is clamped below by a minimum width and kept strictly shorter than the period. Both codes are captured only when the counter wraps, so a knob that moves during a pulse never shortens or stretches that pulse.

Every channel also has a digitized load-current reading. When a channel's reading is at full scale, only that channel's drive is forced low. A one-cycle strobe marks the first tick of each period.

Top module: `pulse_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every `drive` bit and `period_strobe` are 0 after that edge. The counter restarts at tick 0, and the codes present in the final reset cycle become the active setpoints.
- R2: `period_strobe` is high for exactly one cycle, in tick 0 of each period. Consecutive strobes are `PER_MIN + period_code*PER_STEP` cycles apart.
- R3: In each period, a channel that is not masked drives 1 for ticks 0 to W-1 and 0 for the remaining ticks, where W = `width_code*WMUL`. The one exception is tick 0 of the first period after reset, which stays low.
- R4: When `width_code*WMUL` is below `WID_MIN`, the on-time is `WID_MIN` ticks.
- R5: When the width would reach or exceed the active period P, the on-time is P-1 ticks.
- R6: When `PER_MIN + period_code*PER_STEP` exceeds `PER_MAX`, the period is `PER_MAX` ticks.
- R7: Setpoint codes are sampled only at the wrap into tick 0. A change in the middle of a period leaves that period's length and on-time unchanged and takes effect from the next period.
- R8: Channel i's current code is bits [i*CODE_W +: CODE_W] of `cur_codes`. If that code equals all ones at a clock edge, `drive[i]` is 0 after the edge. Codes below all ones, including all ones minus one, do not mask the channel. Masking one channel does not affect the other channels. After a release, the channel's drive rejoins the current pulse on the next cycle.
- R9: With no channel masked, all `drive` bits are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| width_code | input | CODE_W | Digitized on-time setpoint |
| period_code | input | CODE_W | Digitized period setpoint |
| cur_codes | input | NCH*CODE_W | Per-channel current readings, channel i at slice i |
| drive | output | NCH | Registered per-channel drive pulses |
| period_strobe | output | 1 | One-cycle marker of tick 0 in each period |

## Verification
The hardest case to reach is a setpoint change in the middle of a period, because its effect only shows one wrap later. The stimulus locks onto a strobe, changes both codes a few ticks later, and measures the length and on-time of that period and of the following one. The other hard case is a current fault released while a pulse is in progress. The stimulus releases it a fixed number of ticks after a strobe, so the expected number of remaining high cycles is known exactly. A behavioural model that tracks the tick count compares every output on every cycle, including across a reset that arrives mid-run.

// File: rtl/pulse_sync_gen.sv
module pulse_sync_gen #(
  parameter int NCH      = 24,
  parameter int CODE_W   = 12,
  parameter int CNT_W    = 26,
  parameter int WMUL     = 31,
  parameter int WID_MIN  = 5000,
  parameter int PER_MIN  = 1000000,
  parameter int PER_MAX  = 50000000,
  parameter int PER_STEP = 11966
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        width_code,
  input  logic [CODE_W-1:0]        period_code,
  input  logic [NCH*CODE_W-1:0]    cur_codes,
  output logic [NCH-1:0]           drive,
  output logic                     period_strobe
);
  localparam int AW = CNT_W + CODE_W + 1;
  localparam logic [CODE_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt, per_q, wid_q;
  logic [CNT_W-1:0] per_new, wid_new, cnt_nxt, per_nxt, wid_nxt;
  logic [AW-1:0]    per_raw, wid_raw;
  logic [NCH-1:0]   oc;
  logic             wrap, in_pulse;

  assign per_raw = AW'(PER_MIN) + AW'(period_code) * AW'(PER_STEP);
  assign per_new = (per_raw > AW'(PER_MAX)) ? CNT_W'(PER_MAX) : per_raw[CNT_W-1:0];
  assign wid_raw = AW'(width_code) * AW'(WMUL);

  always_comb begin
    if (wid_raw < AW'(WID_MIN))       wid_new = CNT_W'(WID_MIN);
    else if (wid_raw >= AW'(per_new)) wid_new = per_new - CNT_W'(1);
    else                              wid_new = wid_raw[CNT_W-1:0];
  end

  assign wrap     = (cnt == per_q - CNT_W'(1));
  assign cnt_nxt  = wrap ? '0 : cnt + CNT_W'(1);
  assign per_nxt  = wrap ? per_new : per_q;
  assign wid_nxt  = wrap ? wid_new : wid_q;
  assign in_pulse = (cnt_nxt < wid_nxt);

  for (genvar i = 0; i < NCH; i++) begin : g_oc
    assign oc[i] = (cur_codes[i*CODE_W +: CODE_W] == FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt           <= '0;
      per_q         <= per_new;
      wid_q         <= wid_new;
      drive         <= '0;
      period_strobe <= 1'b0;
    end else begin
      cnt           <= cnt_nxt;
      per_q         <= per_nxt;
      wid_q         <= wid_nxt;
      drive         <= {NCH{in_pulse}} & ~oc;
      period_strobe <= wrap;
    end
  end
endmodule

// File: rtl/pulse_sync_gen_chk.sv
module pulse_sync_gen_chk #(
  parameter int NCH    = 24,
  parameter int CODE_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH*CODE_W-1:0] cur_codes,
  input logic [NCH-1:0]        drive,
  input logic                  period_strobe
);
  logic [NCH-1:0] full;
  for (genvar i = 0; i < NCH; i++) begin : g_full
    assign full[i] = &cur_codes[i*CODE_W +: CODE_W];

    a_r8_mask: assert property (@(posedge clk) disable iff (rst)
      full[i] |=> !drive[i]);
  end

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (drive == '0 && !period_strobe));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    period_strobe |=> !period_strobe);

  a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
    (full == '0) |=> (drive == '0 || drive == '1));

  a_r3_high_at_start: assert property (@(posedge clk) disable iff (rst)
    (full == '0) |=> (!period_strobe || drive == '1));
endmodule

bind pulse_sync_gen pulse_sync_gen_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .cur_codes(cur_codes), .drive(drive), .period_strobe(period_strobe)
);

// File: tb/pulse_sync_gen_bench.sv
module pulse_sync_gen_bench;
  localparam int NCH = 24, CW = 12;
  localparam int WMUL = 2, WMIN = 10, PMIN = 100, PMAX = 600, PSTEP = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] wc = 12'd20, pc = 12'd0;
  logic [CW-1:0] cur [NCH];
  logic [NCH*CW-1:0] cur_flat;
  logic [NCH-1:0] drive;
  logic strb;

  int checks = 0, fails = 0;
  string req = "R1";

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) cur_flat[i*CW +: CW] = cur[i];

  pulse_sync_gen #(.NCH(NCH), .CODE_W(CW), .CNT_W(12), .WMUL(WMUL), .WID_MIN(WMIN),
                   .PER_MIN(PMIN), .PER_MAX(PMAX), .PER_STEP(PSTEP)) u_pulse_sync_gen (
    .clk(clk), .rst(rst), .width_code(wc), .period_code(pc), .cur_codes(cur_flat),
    .drive(drive), .period_strobe(strb));

  function automatic int fper(int c);
    int v = PMIN + c * PSTEP;
    return (v > PMAX) ? PMAX : v;
  endfunction

  function automatic int fwid(int c, int p);
    int v = c * WMUL;
    if (v < WMIN) v = WMIN;
    if (v >= p) v = p - 1;
    return v;
  endfunction

  int m_cnt, m_per, m_wid;
  logic [NCH-1:0] m_drive;
  logic m_strb, m_ok = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per = fper(pc); m_wid = fwid(wc, m_per);
      m_drive = '0; m_strb = 1'b0;
    end else begin
      m_strb = (m_cnt == m_per - 1);
      if (m_strb) begin
        m_cnt = 0; m_per = fper(pc); m_wid = fwid(wc, m_per);
      end else m_cnt = m_cnt + 1;
      for (int i = 0; i < NCH; i++) m_drive[i] = (m_cnt < m_wid) && (cur[i] != 12'hFFF);
    end
    m_ok = 1'b1;
  end

  always @(negedge clk) if (m_ok) begin
    checks++;
    if (drive !== m_drive || strb !== m_strb) begin
      fails++;
      $display("FAIL %s cycle compare: drive=%h strobe=%b expected drive=%h strobe=%b",
               req, drive, strb, m_drive, m_strb);
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic meas(int ch, output int len, output int hi);
    do @(negedge clk); while (!strb);
    len = 1; hi = int'(drive[ch]);
    forever begin
      @(negedge clk);
      if (strb) break;
      len++; hi += int'(drive[ch]);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!strb);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int len, hi;
    for (int i = 0; i < NCH; i++) cur[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset drive", int'(drive), 0);
    chk("R1 reset strobe", int'(strb), 0);
    rst = 1'b0;

    req = "R2";
    wait_strobe();
    chk("R9 all channels high at period start", int'(drive == '1), 1);
    meas(5, len, hi);
    chk("R2 period length code 0", len, 100);
    chk("R3 on-time code 20", hi, 40);

    req = "R4"; wc = 12'd2;
    meas(0, len, hi);
    chk("R4 min width clamp", hi, 10);

    req = "R5"; wc = 12'd4095;
    meas(7, len, hi);
    chk("R5 width below period", hi, 99);

    req = "R6"; pc = 12'd4095; wc = 12'd100;
    meas(0, len, hi);
    chk("R6 period max clamp", len, 600);
    chk("R3 on-time code 100", hi, 200);

    req = "R2"; pc = 12'd50; wc = 12'd30;
    meas(0, len, hi);
    chk("R2 period length code 50", len, 250);
    chk("R3 on-time code 30", hi, 60);

    req = "R7";
    fork
      meas(0, len, hi);
      begin wait_strobe(); repeat (5) @(negedge clk); pc = 12'd0; wc = 12'd20; end
    join
    chk("R7 mid-period change keeps length", len, 250);
    chk("R7 mid-period change keeps on-time", hi, 60);
    meas(0, len, hi);
    chk("R7 new period applied", len, 100);
    chk("R7 new on-time applied", hi, 40);

    req = "R8";
    cur[3] = 12'hFFF; cur[17] = 12'hFFF; cur[4] = 12'hFFE;
    meas(3, len, hi);
    chk("R8 channel 3 masked", hi, 0);
    meas(17, len, hi);
    chk("R8 channel 17 masked", hi, 0);
    meas(4, len, hi);
    chk("R8 code below full scale not masked", hi, 40);
    meas(9, len, hi);
    chk("R8 neighbour unaffected", hi, 40);
    fork
      meas(3, len, hi);
      begin wait_strobe(); repeat (10) @(negedge clk); cur[3] = '0; end
    join
    chk("R8 release mid-pulse", hi, 29);
    cur[17] = '0; cur[4] = '0;

    req = "R1";
    wait_strobe();
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset drive", int'(drive), 0);
    rst = 1'b0;
    req = "R3";
    repeat (3) @(negedge clk);
    meas(0, len, hi);
    chk("R2 length after reset", len, 100);
    chk("R9 aligned after reset", int'(drive == '0 || drive == '1), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule